// File: doc/BRIEF.md
# Multiword String Length Sequencer

This block holds the length of a multiword operand and walks a datapath through its words one at a time. Software loads a 5-bit length code with a register write. The code is biased by two, so the code 0 selects a two-word operand and the code 30 selects the largest operand, 32 words. The code 31 has no meaning. A write of 31 is clamped to 30, and an error flag pulses for one cycle.

A start pulse begins an operation. While the operation runs, the block presents a word index together with first-word, last-word and carry-chain-enable flags. The datapath can then propagate a carry from one word into the next. The index advances on each cycle in which the datapath accepts the current word by raising `ready`. Once the last word has been accepted, a one-cycle done pulse ends the operation.

The length code is captured when the operation starts. The stored code is never consumed or altered by running an operation, so the same length can be reused by any number of later operations.

Top module: `strlen_seq`

## Requirements
- R1: After a synchronous reset, `len_code` is 0 and `busy`, `done`, `code_err`, `first_word`, `last_word` and `carry_en` are all 0, with `word_idx` equal to 0.
- R2: A write (`wr_en` high) with a code from 0 to 30 stores that code unchanged. `len_code` shows the new code from the cycle after the write, and `code_err` stays 0.
- R3: A write of code 31 stores 30. `code_err` is high for exactly the one cycle after that write.
- R4: Running an operation never changes `len_code`. Only a write changes it.
- R5: A `start` pulse while idle makes `busy` high from the next cycle with `word_idx` 0. The operation covers exactly stored code + 2 words, indexed 0 upward.
- R6: While busy, `word_idx` advances by one only on a cycle with `ready` high. On a cycle without `ready` it holds.
- R7: While busy, `first_word` is high only at index 0, and `last_word` is high only at index code + 1. `carry_en` is low at index 0 and high at every later index. All three flags are low while idle.
- R8: On the cycle after the last word is accepted, `busy` is 0 and `done` is 1. `done` is high for that single cycle, and `word_idx` returns to 0.
- R9: A `start` pulse while busy is ignored. The index, flags and remaining length are unaffected.
- R10: The operation length is taken from the code stored when `start` is accepted. A write during an operation changes only later operations. A write in the same cycle as `start` applies to the next operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Length register write strobe |
| wr_code | input | 5 | Length code to write (words - 2) |
| start | input | 1 | Begin an operation (ignored while busy) |
| ready | input | 1 | Datapath accepts the current word |
| len_code | output | 5 | Stored length code |
| code_err | output | 1 | One-cycle pulse after an out-of-range write |
| busy | output | 1 | Operation in progress |
| word_idx | output | 5 | Index of the current word |
| first_word | output | 1 | Current word is the first |
| last_word | output | 1 | Current word is the last |
| carry_en | output | 1 | Carry from the previous word is to be used |
| done | output | 1 | One-cycle pulse after the last word is accepted |

## Verification
The assertions check the following on every cycle:
- Clamping of out-of-range writes and the one-cycle error pulse.
- That the stored code holds without a write.
- That the index holds while `ready` is low.
- That `done` is a single pulse.
- That the first-word and carry flags never agree while busy.
- That a start pulse during an operation does not end it.

Only the bench scenarios can show that an operation spans exactly code + 2 words, at lengths 2, 7, 32 and a clamped 32. The same scenarios show that the last-word flag lands on the right index, and that a write during an operation takes effect only for the next one.

// File: rtl/strseq_pkg.sv
package strseq_pkg;
  typedef enum logic {SQ_IDLE = 1'b0, SQ_RUN = 1'b1} sq_state_e;

  function automatic logic [4:0] clamp_code(input logic [4:0] code, input logic [4:0] max_code);
    return (code > max_code) ? max_code : code;
  endfunction
endpackage

// File: rtl/strseq_len_reg.sv
module strseq_len_reg #(
  parameter int CODE_W   = 5,
  parameter int MAX_CODE = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  output logic [CODE_W-1:0] len_q,
  output logic              err_q
);
  localparam logic [CODE_W-1:0] MAXC = CODE_W'(MAX_CODE);

  logic over;
  assign over = wr_code > MAXC;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= wr_en && over;
      if (wr_en) len_q <= over ? MAXC : wr_code;
    end
  end

  // R3: clamped value and error pulse
  p_clamp_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_code > MAXC) |=> (len_q == MAXC && err_q));
  p_err_only_after_write_r3: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> !err_q);
  // R2: legal code stored as written
  p_legal_store_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_code <= MAXC) |=> (len_q == $past(wr_code) && !err_q));
  // R4: code only changes on a write
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(len_q));
endmodule

// File: rtl/strseq_walker.sv
module strseq_walker
  import strseq_pkg::*;
#(
  parameter int CODE_W = 5,
  parameter int IDX_W  = 5,
  parameter int BIAS   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              ready,
  input  logic [CODE_W-1:0] len_code,
  output logic              busy,
  output logic [IDX_W-1:0]  idx,
  output logic              first_q,
  output logic              last_q,
  output logic              carry_q,
  output logic              done_q
);
  sq_state_e          state;
  logic [IDX_W-1:0]   last_idx;
  logic [IDX_W-1:0]   nxt_idx;

  assign busy    = (state == SQ_RUN);
  assign nxt_idx = idx + IDX_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      idx      <= '0;
      last_idx <= '0;
      first_q  <= 1'b0;
      last_q   <= 1'b0;
      carry_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (start) begin
            state    <= SQ_RUN;
            idx      <= '0;
            last_idx <= IDX_W'(len_code) + IDX_W'(BIAS - 1);
            first_q  <= 1'b1;
            last_q   <= 1'b0;
            carry_q  <= 1'b0;
          end
        end
        default: begin
          if (ready) begin
            if (idx == last_idx) begin
              state   <= SQ_IDLE;
              idx     <= '0;
              first_q <= 1'b0;
              last_q  <= 1'b0;
              carry_q <= 1'b0;
              done_q  <= 1'b1;
            end else begin
              idx     <= nxt_idx;
              first_q <= 1'b0;
              carry_q <= 1'b1;
              last_q  <= (nxt_idx == last_idx);
            end
          end
        end
      endcase
    end
  end

  // R6: index holds without ready
  p_idx_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && !ready) |=> ($stable(idx) && busy));
  // R8: done is a single pulse with the sequencer idle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (!busy && idx == '0) ##1 !done_q);
  // R7: first word and carry enable are complementary while running
  p_first_carry_r7: assert property (@(posedge clk) disable iff (rst)
    busy |-> (first_q != carry_q));
  p_first_idx_r7: assert property (@(posedge clk) disable iff (rst)
    first_q |-> (busy && idx == '0));
  p_idle_flags_r7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(first_q || last_q || carry_q));
  // R9: start during a run never ends it early
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !ready) |=> busy);
  // R5: index stays within the captured length
  p_idx_range_r5: assert property (@(posedge clk) disable iff (rst)
    busy |-> (idx <= last_idx));
endmodule

// File: rtl/strlen_seq.sv
module strlen_seq #(
  parameter int MAX_WORDS = 32,
  parameter int BIAS      = 2,
  parameter int CODE_W    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              start,
  input  logic              ready,
  output logic [CODE_W-1:0] len_code,
  output logic              code_err,
  output logic              busy,
  output logic [CODE_W-1:0] word_idx,
  output logic              first_word,
  output logic              last_word,
  output logic              carry_en,
  output logic              done
);
  localparam int MAX_CODE = MAX_WORDS - BIAS;
  localparam int IDX_W    = $clog2(MAX_WORDS);

  logic [IDX_W-1:0] idx;

  strseq_len_reg #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE)) u_len (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_code(wr_code),
    .len_q(len_code), .err_q(code_err)
  );

  strseq_walker #(.CODE_W(CODE_W), .IDX_W(IDX_W), .BIAS(BIAS)) u_walk (
    .clk(clk), .rst(rst), .start(start), .ready(ready), .len_code(len_code),
    .busy(busy), .idx(idx), .first_q(first_word), .last_q(last_word),
    .carry_q(carry_en), .done_q(done)
  );

  assign word_idx = CODE_W'(idx);
endmodule

// File: tb/tb_strlen_seq.sv
module tb_strlen_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [4:0] wr_code = '0;
  logic       start = 1'b0;
  logic       ready = 1'b0;
  logic [4:0] len_code;
  logic       code_err, busy, first_word, last_word, carry_en, done;
  logic [4:0] word_idx;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  strlen_seq dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_code(wr_code), .start(start),
    .ready(ready), .len_code(len_code), .code_err(code_err), .busy(busy),
    .word_idx(word_idx), .first_word(first_word), .last_word(last_word),
    .carry_en(carry_en), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      finish_run();
    end
  end

  // write a code; inputs change at the falling edge
  task automatic write_code(input int code, input int exp_len, input bit exp_err);
    wr_en = 1'b1; wr_code = 5'(code);
    @(negedge clk);
    wr_en = 1'b0;
    chk(len_code == 5'(exp_len), "R2/R3 stored code", len_code, exp_len);
    chk(code_err == exp_err, "R2/R3 error flag", code_err, exp_err);
    @(negedge clk);
    chk(code_err == 1'b0, "R3 error lasts one cycle", code_err, 0);
  endtask

  // run one operation of 'words' words and check every word
  task automatic run_string(input int words, input bit stall, input bit poke,
                            input bit write_mid, input int exp_len_after);
    start = 1'b1;
    if (write_mid) begin wr_en = 1'b1; wr_code = 5'd9; end // R10: same-cycle write
    @(negedge clk);
    start = 1'b0; wr_en = 1'b0;
    for (int w = 0; w < words; w++) begin
      chk(busy == 1'b1, "R5 busy during run", busy, 1);
      chk(word_idx == 5'(w), "R5/R6 word index", word_idx, w);
      chk(first_word == (w == 0), "R7 first_word", first_word, w == 0);
      chk(last_word == (w == words - 1), "R7 last_word", last_word, w == words - 1);
      chk(carry_en == (w != 0), "R7 carry_en", carry_en, w != 0);
      if (stall && (w % 3 == 1)) begin
        ready = 1'b0;
        if (poke) start = 1'b1; // R9
        @(negedge clk);
        start = 1'b0;
        chk(word_idx == 5'(w), "R6 hold without ready", word_idx, w);
        chk(busy == 1'b1, "R9 start ignored while busy", busy, 1);
      end
      ready = 1'b1;
      if (poke && w == 2) start = 1'b1; // R9: start with ready
      if (write_mid && w == 0) begin wr_en = 1'b1; wr_code = 5'd3; end // R10
      @(negedge clk);
      ready = 1'b0; start = 1'b0; wr_en = 1'b0;
    end
    chk(busy == 1'b0, "R8 busy drops", busy, 0);
    chk(done == 1'b1, "R8 done after last word", done, 1);
    chk(word_idx == 5'd0, "R8 index back to 0", word_idx, 0);
    chk(!(first_word || last_word || carry_en), "R7 flags low when idle",
        {first_word, last_word, carry_en}, 0);
    @(negedge clk);
    chk(done == 1'b0, "R8 done single cycle", done, 0);
    chk(len_code == 5'(exp_len_after), "R4 code kept after run", len_code, exp_len_after);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(len_code == 5'd0 && busy == 0 && done == 0 && code_err == 0 && word_idx == 0,
        "R1 reset state", {len_code, busy, done, code_err}, 0);
    rst = 1'b0;
    @(negedge clk);
    // default code 0 -> two words
    run_string(2, 0, 0, 0, 0);
    write_code(5, 5, 0);
    run_string(7, 1, 1, 0, 5);
    write_code(30, 30, 0);
    run_string(32, 1, 0, 0, 30);
    write_code(31, 30, 1);
    run_string(32, 0, 1, 0, 30);
    write_code(0, 0, 0);
    // R10: writes during the run (same cycle as start, then mid-run) apply later
    run_string(2, 0, 0, 1, 3);
    run_string(5, 1, 0, 0, 3);
    // R9: idle ready pulses without start keep the block idle
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
    chk(busy == 1'b0 && done == 1'b0, "R5 ready alone does not start", busy, 0);
    finish_run();
  end
endmodule